// File: doc/BRIEF.md
# Low-Power Halt and Wake Controller

This block governs the halt state of a small microcontroller core. When the core runs a halt instruction it raises `halt_req`. The block then drops the system clock enable, sets the power-down flag and clears the time-out flag. It also tells the watchdog whether to clear itself and whether it may keep counting. The watchdog may be clocked from its own oscillator or from the system clock, and it stops while asleep in the second case.

While the device sleeps, the block watches four wake sources: an external reset request, the watchdog overflow, interrupt requests that arrived after the halt, and falling edges on pins of an input port that have their own wake enable. Port pins pass through a two-flop synchronizer and a registered previous value. All logic runs on an always-on low-speed clock.

A wake raises the clock enable again. In the same cycle the block gives a one-cycle `wake_valid` with a 2-bit code. The code tells the core how to continue: a full reset, a watchdog reset of only the program counter and the stack pointer, a resume at the instruction after the halt, or the normal interrupt response.

Top module: `slp_wake_ctrl`

## Requirements
- R1: After reset, `sys_clk_en` is 1, `pdf` and `to_flag` are 0, and `wake_valid` and `wdt_clr` are 0.
- R2: `halt_req` while awake sets `sys_clk_en` to 0, `pdf` to 1 and `to_flag` to 0 on the next clock edge. `halt_req` while asleep has no effect.
- R3: `clr_wdt` clears `pdf` on the next edge. A halt in the same cycle takes precedence.
- R4: `to_flag` is set by `wdt_ovf` whenever the watchdog is running. It is running always while awake. While asleep it runs only when `wdt_src_own`=1 and `wdt_osc_off`=0.
- R5: `ext_rst` while asleep wakes with code 2'b00 (full reset). `pdf` and `to_flag` keep their values.
- R6: A running watchdog's overflow while asleep wakes with code 2'b01 (program counter and stack pointer reset). It sets `to_flag` and leaves `pdf` at 1. When the watchdog is not running, the overflow is ignored and the block stays asleep.
- R7: A falling edge on port pin i while asleep wakes with code 2'b10 (resume) only if `port_wake_en[i]`=1. It appears three clock edges after the pin changes. Rising edges and disabled pins do not wake.
- R8: While asleep, an interrupt request that was not pending at halt entry wakes the device. The code is 2'b11 (interrupt response) if that request's enable is 1 and `stack_full`=0, and 2'b10 (resume, request left pending) otherwise.
- R9: An interrupt request that was already pending when the halt was taken cannot wake the device.
- R10: When several wake sources are active in one cycle, the code follows the priority external reset, then watchdog, then interrupt, then pin edge.
- R11: `wake_valid` is high for exactly one cycle per wake, in the same cycle that `sys_clk_en` returns to 1.
- R12: `wdt_clr` pulses for one cycle right after halt entry only when `wdt_src_own`=1 and `wdt_osc_off`=0. `wdt_run` is 1 while awake and equals `wdt_src_own & ~wdt_osc_off` while asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running low-speed clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| halt_req | input | 1 | Halt instruction executed |
| clr_wdt | input | 1 | Clear-watchdog command |
| ext_rst | input | 1 | External reset request |
| port_in | input | PORT_W | Input port pins (idle high) |
| port_wake_en | input | PORT_W | Per-pin falling-edge wake enable |
| irq_req | input | NIRQ | Interrupt request flags |
| irq_en | input | NIRQ | Interrupt enables |
| stack_full | input | 1 | Call stack has no free level |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| wdt_src_own | input | 1 | 1: watchdog clocked by its own oscillator, 0: by system clock |
| wdt_osc_off | input | 1 | Configuration: watchdog oscillator disabled |
| sys_clk_en | output | 1 | System clock enable |
| pdf | output | 1 | Power-down flag |
| to_flag | output | 1 | Watchdog time-out flag |
| wdt_clr | output | 1 | Clear pulse to the watchdog counter |
| wdt_run | output | 1 | Watchdog allowed to count |
| wake_valid | output | 1 | One-cycle wake strobe |
| wake_code | output | 2 | Exit kind: 00 full reset, 01 watchdog reset, 10 resume, 11 interrupt |

## Verification
The bench builds the block with PORT_W=4 and NIRQ=2. This keeps every pin crossed with every enable pattern (64 cases) within a full sweep. It also covers every interrupt index crossed with every enable pair and both stack states. All 15 combinations of simultaneous wake sources are sampled, so the priority order is checked completely. Both watchdog clock-source settings are crossed with the oscillator-disable option, which checks the watchdog's sleep behaviour in each of its four configurations.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        WK_FULL   = 2'b00,
        WK_WDT    = 2'b01,
        WK_RESUME = 2'b10,
        WK_VECTOR = 2'b11
    } wake_code_t;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } pwr_state_t;

    typedef struct packed {
        logic ext;
        logic wdt;
        logic irq;
        logic irq_svc;
        logic pin;
    } wake_src_t;

    function automatic logic wdt_counts(input logic asleep, input logic src_own,
                                        input logic osc_off);
        return !asleep || (src_own && !osc_off);
    endfunction

endpackage

// File: rtl/slp_pin_edge.sv
module slp_pin_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] fall
);
    logic [W-1:0] s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
        end else begin
            s1_q   <= pin_in;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign fall = prev_q & ~s2_q;

endmodule

// File: rtl/slp_wake_arb.sv
module slp_wake_arb
    import slp_pkg::*;
(
    input  wake_src_t  src,
    output logic       any,
    output wake_code_t code
);
    always_comb begin
        any  = src.ext | src.wdt | src.irq | src.pin;
        code = WK_RESUME;
        if (src.ext)
            code = WK_FULL;
        else if (src.wdt)
            code = WK_WDT;
        else if (src.irq)
            code = src.irq_svc ? WK_VECTOR : WK_RESUME;
    end

endmodule

// File: rtl/slp_status.sv
module slp_status (
    input  logic clk,
    input  logic rst,
    input  logic halt_entry,
    input  logic clr_wdt,
    input  logic wdt_tick,
    output logic pdf,
    output logic to_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pdf     <= 1'b0;
            to_flag <= 1'b0;
        end else begin
            if (halt_entry)
                pdf <= 1'b1;
            else if (clr_wdt)
                pdf <= 1'b0;

            if (halt_entry)
                to_flag <= 1'b0;
            else if (wdt_tick)
                to_flag <= 1'b1;
        end
    end

    AST_HALT_SETS_PDF: assert property (@(posedge clk) disable iff (rst)
        halt_entry |=> (pdf && !to_flag)); // R2
    AST_CLR_DROPS_PDF: assert property (@(posedge clk) disable iff (rst)
        (clr_wdt && !halt_entry) |=> !pdf); // R3
    AST_TICK_SETS_TO: assert property (@(posedge clk) disable iff (rst)
        (wdt_tick && !halt_entry) |=> to_flag); // R4

endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
    import slp_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int NIRQ   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_req,
    input  logic              clr_wdt,
    input  logic              ext_rst,
    input  logic [PORT_W-1:0] port_in,
    input  logic [PORT_W-1:0] port_wake_en,
    input  logic [NIRQ-1:0]   irq_req,
    input  logic [NIRQ-1:0]   irq_en,
    input  logic              stack_full,
    input  logic              wdt_ovf,
    input  logic              wdt_src_own,
    input  logic              wdt_osc_off,
    output logic              sys_clk_en,
    output logic              pdf,
    output logic              to_flag,
    output logic              wdt_clr,
    output logic              wdt_run,
    output logic              wake_valid,
    output logic [1:0]        wake_code
);
    pwr_state_t      state_q;
    logic [NIRQ-1:0] armed_q;
    logic            wake_q;
    wake_code_t      code_q;
    logic            clr_q;

    logic              asleep;
    logic              halt_entry;
    logic              wdt_tick;
    logic [PORT_W-1:0] fall;
    logic [NIRQ-1:0]   irq_new;
    wake_src_t         src;
    logic              wake_any;
    wake_code_t        wake_sel;

    assign asleep     = (state_q == ST_SLEEP);
    assign halt_entry = !asleep && halt_req;
    assign wdt_run    = wdt_counts(asleep, wdt_src_own, wdt_osc_off);
    assign wdt_tick   = wdt_ovf && wdt_run;
    assign irq_new    = irq_req & armed_q;

    slp_pin_edge #(.W(PORT_W)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_in (port_in),
        .fall   (fall)
    );

    always_comb begin
        src.ext     = asleep && ext_rst;
        src.wdt     = asleep && wdt_tick;
        src.irq     = asleep && (|irq_new);
        src.irq_svc = (|(irq_new & irq_en)) && !stack_full;
        src.pin     = asleep && (|(fall & port_wake_en));
    end

    slp_wake_arb u_arb (
        .src  (src),
        .any  (wake_any),
        .code (wake_sel)
    );

    slp_status u_status (
        .clk        (clk),
        .rst        (rst),
        .halt_entry (halt_entry),
        .clr_wdt    (clr_wdt),
        .wdt_tick   (wdt_tick),
        .pdf        (pdf),
        .to_flag    (to_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            armed_q <= '0;
            wake_q  <= 1'b0;
            code_q  <= WK_FULL;
            clr_q   <= 1'b0;
        end else begin
            wake_q <= 1'b0;
            clr_q  <= 1'b0;
            if (halt_entry) begin
                state_q <= ST_SLEEP;
                armed_q <= ~irq_req;
                clr_q   <= wdt_src_own && !wdt_osc_off;
            end else if (wake_any) begin
                state_q <= ST_RUN;
                wake_q  <= 1'b1;
                code_q  <= wake_sel;
            end
        end
    end

    assign sys_clk_en = !asleep;
    assign wake_valid = wake_q;
    assign wake_code  = code_q;
    assign wdt_clr    = clr_q;

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wake_valid |=> !wake_valid); // R11
    AST_WAKE_WITH_CLK: assert property (@(posedge clk) disable iff (rst)
        wake_valid |-> sys_clk_en); // R11
    AST_EXT_WINS: assert property (@(posedge clk) disable iff (rst)
        (asleep && ext_rst) |=> (wake_valid && wake_code == 2'b00)); // R10
    AST_WDT_WAKE_TO: assert property (@(posedge clk) disable iff (rst)
        (wake_valid && wake_code == 2'b01) |-> to_flag); // R6
    AST_CLR_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        wdt_clr |-> !sys_clk_en); // R12

endmodule

// File: tb/tb_slp_wake_ctrl.sv
module tb_slp_wake_ctrl;
    localparam int PW = 4;
    localparam int NI = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt_req = 0, clr_wdt = 0, ext_rst = 0, stack_full = 0;
    logic wdt_ovf = 0, wdt_src_own = 1, wdt_osc_off = 0;
    logic [PW-1:0] port_in = '1, port_wake_en = '0;
    logic [NI-1:0] irq_req = '0, irq_en = '0;
    logic sys_clk_en, pdf, to_flag, wdt_clr, wdt_run, wake_valid;
    logic [1:0] wake_code;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    slp_wake_ctrl #(.PORT_W(PW), .NIRQ(NI)) dut (
        .clk(clk), .rst(rst), .halt_req(halt_req), .clr_wdt(clr_wdt),
        .ext_rst(ext_rst), .port_in(port_in), .port_wake_en(port_wake_en),
        .irq_req(irq_req), .irq_en(irq_en), .stack_full(stack_full),
        .wdt_ovf(wdt_ovf), .wdt_src_own(wdt_src_own), .wdt_osc_off(wdt_osc_off),
        .sys_clk_en(sys_clk_en), .pdf(pdf), .to_flag(to_flag), .wdt_clr(wdt_clr),
        .wdt_run(wdt_run), .wake_valid(wake_valid), .wake_code(wake_code)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sleep_in();
        halt_req = 1'b1;
        tick(1);
        halt_req = 1'b0;
    endtask

    task automatic kick_out();
        ext_rst = 1'b1;
        tick(1);
        ext_rst = 1'b0;
        tick(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 clk_en", sys_clk_en, 1);
        chk("R1 pdf", pdf, 0);
        chk("R1 to", to_flag, 0);
        chk("R1 wake", wake_valid, 0);
        chk("R1 wdt_clr", wdt_clr, 0);

        // R4 overflow while awake sets TO
        wdt_ovf = 1; tick(1); wdt_ovf = 0;
        chk("R4 to awake", to_flag, 1);

        // R2 halt entry, R12 clear pulse
        sleep_in();
        chk("R2 clk_en", sys_clk_en, 0);
        chk("R2 pdf", pdf, 1);
        chk("R2 to", to_flag, 0);
        chk("R12 clr pulse", wdt_clr, 1);
        tick(1);
        chk("R12 clr one cycle", wdt_clr, 0);
        halt_req = 1; tick(1); halt_req = 0;
        chk("R2 halt asleep ignored", sys_clk_en, 0);
        chk("R2 halt asleep no wake", wake_valid, 0);

        // R5 external reset wake
        ext_rst = 1; tick(1); ext_rst = 0;
        chk("R5 wake", wake_valid, 1);
        chk("R5 code", wake_code, 2'b00);
        chk("R11 clk_en", sys_clk_en, 1);
        chk("R5 pdf kept", pdf, 1);
        chk("R5 to kept", to_flag, 0);
        tick(1);
        chk("R11 one cycle", wake_valid, 0);

        // R3 clear-watchdog command
        clr_wdt = 1; tick(1); clr_wdt = 0;
        chk("R3 pdf cleared", pdf, 0);
        clr_wdt = 1; halt_req = 1; tick(1); clr_wdt = 0; halt_req = 0;
        chk("R3 halt wins", pdf, 1);
        kick_out();

        // R6 / R12 / R4: watchdog configurations
        for (int c = 0; c < 4; c++) begin
            logic live;
            wdt_src_own = c[0];
            wdt_osc_off = c[1];
            live = c[0] & ~c[1];
            sleep_in();
            chk("R12 clr by cfg", wdt_clr, live);
            chk("R12 run asleep", wdt_run, live);
            wdt_ovf = 1; tick(1); wdt_ovf = 0;
            chk("R6 wake by cfg", wake_valid, live);
            chk("R4 to by cfg", to_flag, live);
            chk("R6 pdf kept", pdf, 1);
            if (live) chk("R6 code", wake_code, 2'b01);
            else begin
                chk("R6 still asleep", sys_clk_en, 0);
                kick_out();
            end
            chk("R12 run awake", wdt_run, 1);
            tick(1);
        end
        wdt_src_own = 1; wdt_osc_off = 0;

        // R7 pin falling-edge sweep
        for (int p = 0; p < PW; p++) begin
            for (int e = 0; e < (1 << PW); e++) begin
                logic hit;
                hit = e[p];
                port_wake_en = e[PW-1:0];
                sleep_in();
                port_in[p] = 1'b0;
                tick(2);
                chk("R7 not early", wake_valid, 0);
                tick(1);
                chk("R7 wake iff enabled", wake_valid, hit);
                if (hit) chk("R7 code", wake_code, 2'b10);
                else kick_out();
                port_in = '1;
                tick(3);
            end
        end
        // R7 rising edge ignored
        port_wake_en = '1;
        port_in[0] = 1'b0;
        tick(3);
        sleep_in();
        port_in[0] = 1'b1;
        tick(4);
        chk("R7 rising ignored", sys_clk_en, 0);
        kick_out();
        port_wake_en = '0;

        // R8 interrupt path sweep
        for (int i = 0; i < NI; i++) begin
            for (int e = 0; e < (1 << NI); e++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [1:0] exp;
                    irq_en = e[NI-1:0];
                    stack_full = s[0];
                    exp = (e[i] && s == 0) ? 2'b11 : 2'b10;
                    sleep_in();
                    irq_req[i] = 1'b1;
                    tick(1);
                    chk("R8 wake", wake_valid, 1);
                    chk("R8 code", wake_code, exp);
                    irq_req = '0;
                    tick(1);
                end
            end
        end
        stack_full = 0;

        // R9 pending request blocks its own wake
        irq_en = '1;
        for (int i = 0; i < NI; i++) begin
            irq_req[i] = 1'b1;
            tick(1);
            sleep_in();
            tick(2);
            chk("R9 pending blocked", sys_clk_en, 0);
            irq_req[1-i] = 1'b1;
            tick(1);
            chk("R9 other irq wakes", wake_valid, 1);
            chk("R9 other code", wake_code, 2'b11);
            irq_req = '0;
            tick(1);
        end

        // R10 priority over all combinations
        for (int m = 1; m < 16; m++) begin
            logic [1:0] exp;
            exp = m[3] ? 2'b00 : m[2] ? 2'b01 : m[1] ? 2'b11 : 2'b10;
            port_wake_en = m[0] ? 4'b0001 : 4'b0000;
            sleep_in();
            if (m[0]) port_in[0] = 1'b0;
            tick(2);
            ext_rst = m[3];
            wdt_ovf = m[2];
            irq_req[0] = m[1];
            tick(1);
            chk("R10 wake", wake_valid, 1);
            chk("R10 priority code", wake_code, exp);
            ext_rst = 0; wdt_ovf = 0; irq_req = '0;
            port_in = '1;
            tick(3);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule